// File: doc/BRIEF.md
# Programmable baud-rate clock generator

This block turns one of three tick sources into a baud clock for serial controllers and an output pin. The sources are the block clock itself, used as a dedicated internal baud reference, and two external clock pins. The external pins are synchronised and edge-detected. They are never used as clock nets. The chosen ticks pass through an optional divide-by-16 prescaler and then a 12-bit counter divider. The counter divides by the programmed value plus one. Its output is a registered level with a near-even duty cycle.

Control comes from plain configuration inputs: an enable, a source code, a prescale bit, the divide value and an autobaud arm pulse. The divide value and the prescale bit may be changed while the block runs. A change takes effect only at the counter's terminal count, so the output never carries a runt phase.

An arm pulse puts the generator into an autobaud hold. The divider stays cleared and the output stays low until the receive-data line shows its first falling edge. A small state machine with three states handles this:

- **OFF**: the block is disabled.
- **HOLD**: the block is waiting for the start edge.
- **RUN**: the block is counting.

The transitions are:

- **OFF→RUN**: enable is set and no request is pending.
- **OFF→HOLD**: enable is set and a request is pending.
- **RUN→HOLD**: a request is pending.
- **HOLD→RUN**: a falling edge is seen on the receive line.
- **any→OFF**: enable is cleared.

Top module: `baud_gen`

## Requirements
- R1: Synchronous reset drives baud_out and ab_busy low. While enable is low, the divider is cleared, and baud_out is low from the first clock edge after enable drops. Dropping enable does not clear a pending autobaud request.
- R2: Source code 0 makes every block clock a tick. With ratio N = cfg_div + 1 and N of 2 or more, baud_out is low for ceil(N/2) ticks and high for floor(N/2) ticks of each period. The low phase comes first after a start.
- R3: With cfg_div = 0 (ratio 1), baud_out is high for exactly one block clock per prescaled tick. With source 0 and the prescaler off, baud_out is therefore steadily high.
- R4: When cfg_pre16 is 1, only every sixteenth tick reaches the counter, so each phase lasts 16 times as long.
- R5: Source code 1 selects ext_clk_a and code 2 selects ext_clk_b. Each rising edge of the selected pin, after a two-flop synchroniser, is one tick. The unselected pin has no effect.
- R6: Source code 3 supplies no ticks. baud_out keeps its level for as long as code 3 is held, and toggling resumes when a real source is chosen again.
- R7: New cfg_div and cfg_pre16 values written while running are adopted only at terminal count. The phase in progress completes with the old setting, and all later phases follow the new one.
- R8: While a request is pending and enable is set, baud_out stays low. Take rxd falling before clock edge 1. ab_busy clears at edge 3, baud_out stays low through edge 4 and first goes high at edge 5 with a ratio of 4.
- R9: An ab_arm pulse sets ab_busy at the next edge. If the block is running, baud_out is low from the third edge onward and stays low while the request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the internal baud reference (source 0) |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Generator enable |
| cfg_src | input | 2 | Tick source: 0 internal, 1 ext_clk_a, 2 ext_clk_b, 3 none |
| cfg_pre16 | input | 1 | 1 inserts the divide-by-16 prescaler |
| cfg_div | input | 12 | Divide value; ratio is cfg_div + 1 |
| ab_arm | input | 1 | One-cycle pulse that requests an autobaud hold |
| ext_clk_a | input | 1 | External clock pin A, asynchronous |
| ext_clk_b | input | 1 | External clock pin B, asynchronous |
| rxd | input | 1 | Receive-data line watched for the start edge, asynchronous |
| baud_out | output | 1 | Generated baud clock for the pin and internal controllers |
| ab_busy | output | 1 | Autobaud request pending |

## Verification
The latencies are as follows:

- Enable changes, arm pulses and reset act on the outputs one edge after they are driven.
- A start is seen on the outputs two edges after the arm state takes effect.
- A receive-line fall passes through the synchroniser before it acts, so ab_busy drops at the third edge and baud_out first rises at the fifth.

The bench drives inputs just after a falling clock edge and samples just after the next one. It therefore counts those latencies edge by edge and checks each result at exactly that sample. Divide ratios are checked by measuring complete high and low run lengths from a rising output. Measuring only complete runs keeps each result independent of the phase at which a source started.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    typedef enum logic [1:0] {
        SRC_INT   = 2'd0,
        SRC_EXT_A = 2'd1,
        SRC_EXT_B = 2'd2,
        SRC_NONE  = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } ctl_state_e;

    localparam int PRE_RATIO_DEF = 16;
    localparam int DIV_W_DEF     = 12;
    localparam int SYNC_DEF      = 2;

endpackage

// File: rtl/baud_edge_sync.sv
module baud_edge_sync #(
    parameter int   STAGES    = 2,
    parameter logic RST_VAL   = 1'b0,
    parameter bit   FALL_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_pulse
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= {(STAGES+1){RST_VAL}};
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    generate
        if (FALL_EDGE) begin : g_fall
            assign edge_pulse = ~sh_q[STAGES-1] & sh_q[STAGES];
        end else begin : g_rise
            assign edge_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];
        end
    endgenerate

endmodule

// File: rtl/baud_ctrl.sv
module baud_ctrl
    import baud_gen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_en,
    input  logic ab_arm,
    input  logic rx_fall,
    output logic counting,
    output logic ab_busy
);
    ctl_state_e state_q, state_d;
    logic       ab_q, ab_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            ab_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ab_q    <= ab_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cfg_en) state_d = ab_q ? ST_HOLD : ST_RUN;
            end
            ST_RUN: begin
                if (!cfg_en)   state_d = ST_OFF;
                else if (ab_q) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!cfg_en)      state_d = ST_OFF;
                else if (rx_fall) state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // request flag: a new arm pulse wins over a same-cycle start edge
    always_comb begin
        ab_d = ab_q;
        if (ab_arm)                                         ab_d = 1'b1;
        else if (state_q == ST_HOLD && cfg_en && rx_fall)   ab_d = 1'b0;
    end

    // outputs
    always_comb begin
        counting = (state_q == ST_RUN);
        ab_busy  = ab_q;
    end

    // R8
    hold_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && cfg_en && !rx_fall) |=> (state_q == ST_HOLD));

    // R8
    ab_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && cfg_en && rx_fall && !ab_arm) |=> (!ab_busy && counting));

    // R9
    arm_set_chk: assert property (@(posedge clk) disable iff (rst)
        ab_arm |=> ab_busy);

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int DIV_W     = 12,
    parameter int PRE_RATIO = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             tick,
    input  logic             cfg_pre,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             baud_out
);
    localparam int PRE_W = $clog2(PRE_RATIO);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

    logic             pre_q;
    logic [DIV_W-1:0] div_q, cnt_q, cnt_nx, div_eff;
    logic [PRE_W-1:0] pcnt_q;
    logic             out_q, out_nx, ptick, term;
    logic [DIV_W:0]   low_ph;

    assign ptick   = pre_q ? (tick && pcnt_q == PRE_LAST) : tick;
    assign term    = go && ptick && (cnt_q == div_q);
    assign div_eff = term ? cfg_div : div_q;
    assign low_ph  = ({1'b0, div_eff} + (DIV_W+1)'(2)) >> 1;

    always_comb begin
        if (term)       cnt_nx = '0;
        else if (ptick) cnt_nx = cnt_q + DIV_W'(1);
        else            cnt_nx = cnt_q;
        if (div_eff == '0) out_nx = ptick;
        else               out_nx = ({1'b0, cnt_nx} >= low_ph);
    end

    always_ff @(posedge clk) begin
        if (rst || !go) begin
            pcnt_q <= '0;
            cnt_q  <= '0;
            out_q  <= 1'b0;
            div_q  <= cfg_div;
            pre_q  <= cfg_pre;
        end else begin
            if (pre_q && tick) pcnt_q <= (pcnt_q == PRE_LAST) ? '0 : pcnt_q + PRE_W'(1);
            cnt_q <= cnt_nx;
            out_q <= out_nx;
            if (term) begin
                div_q <= cfg_div;
                pre_q <= cfg_pre;
            end
        end
    end

    assign baud_out = out_q;

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !go |=> !baud_out);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> (cnt_q <= div_q));

    // R7
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !term) |=> $stable(div_q));

    // R4
    pcnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pre_q |-> (pcnt_q == '0));

    // R6
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !tick && div_q != '0) |=> $stable(baud_out));

endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_gen_pkg::*;
#(
    parameter int DIV_W     = DIV_W_DEF,
    parameter int PRE_RATIO = PRE_RATIO_DEF,
    parameter int SYNC      = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic [1:0]       cfg_src,
    input  logic             cfg_pre16,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             ab_arm,
    input  logic             ext_clk_a,
    input  logic             ext_clk_b,
    input  logic             rxd,
    output logic             baud_out,
    output logic             ab_busy
);
    logic rise_a, rise_b, rx_fall, counting, go, tick;

    baud_edge_sync #(.STAGES(SYNC), .RST_VAL(1'b0), .FALL_EDGE(1'b0)) u_sync_a (
        .clk(clk), .rst(rst), .din(ext_clk_a), .edge_pulse(rise_a));

    baud_edge_sync #(.STAGES(SYNC), .RST_VAL(1'b0), .FALL_EDGE(1'b0)) u_sync_b (
        .clk(clk), .rst(rst), .din(ext_clk_b), .edge_pulse(rise_b));

    baud_edge_sync #(.STAGES(SYNC), .RST_VAL(1'b1), .FALL_EDGE(1'b1)) u_sync_rx (
        .clk(clk), .rst(rst), .din(rxd), .edge_pulse(rx_fall));

    always_comb begin
        unique case (src_sel_e'(cfg_src))
            SRC_INT:   tick = 1'b1;
            SRC_EXT_A: tick = rise_a;
            SRC_EXT_B: tick = rise_b;
            default:   tick = 1'b0;
        endcase
    end

    baud_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .ab_arm(ab_arm),
        .rx_fall(rx_fall), .counting(counting), .ab_busy(ab_busy));

    assign go = counting & cfg_en;

    baud_divider #(.DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO)) u_div (
        .clk(clk), .rst(rst), .go(go), .tick(tick), .cfg_pre(cfg_pre16),
        .cfg_div(cfg_div), .baud_out(baud_out));

endmodule

// File: tb/test_baud_gen.sv
`timescale 1ns/100ps
module test_baud_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_src = 2'd0;
    logic        cfg_pre16 = 1'b0;
    logic [11:0] cfg_div = 12'd0;
    logic        ab_arm = 1'b0;
    logic        ext_clk_a = 1'b0;
    logic        ext_clk_b = 1'b0;
    logic        rxd = 1'b1;
    logic        baud_out, ab_busy;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    // pin A period 4 clocks, pin B period 6 clocks, phased off the clock edges
    initial begin #1;   forever #10 ext_clk_a = ~ext_clk_a; end
    initial begin #1.5; forever #15 ext_clk_b = ~ext_clk_b; end

    baud_gen i_baud_gen (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_src(cfg_src),
        .cfg_pre16(cfg_pre16), .cfg_div(cfg_div), .ab_arm(ab_arm),
        .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b), .rxd(rxd),
        .baud_out(baud_out), .ab_busy(ab_busy));

    // columns: src, pre16, div, expected high, expected low, requirement number
    localparam int NVEC = 7;
    localparam int VEC [NVEC][6] = '{
        '{0, 0, 3,  2,  2, 2},   // R2 ratio 4
        '{0, 0, 4,  2,  3, 2},   // R2 ratio 5
        '{0, 0, 1,  1,  1, 2},   // R2 ratio 2
        '{0, 1, 1, 16, 16, 4},   // R4 prescaled ratio 2
        '{1, 0, 1,  4,  4, 5},   // R5 pin A, ratio 2
        '{2, 0, 2,  6, 12, 5},   // R5 pin B, ratio 3
        '{0, 1, 0,  1, 15, 3}    // R3 ratio 1 behind prescaler
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(output int h, output int l);
        int g;
        h = 0; l = 0; g = 0;
        @(negedge clk);
        while (baud_out !== 1'b0 && g < 400) begin @(negedge clk); g++; end
        while (baud_out !== 1'b1 && g < 400) begin @(negedge clk); g++; end
        while (baud_out === 1'b1 && g < 400) begin h++; @(negedge clk); g++; end
        while (baud_out === 1'b0 && g < 400) begin l++; @(negedge clk); g++; end
        if (g >= 400) begin h = -1; l = -1; end
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int h, l;
        int runs [3];
        int nr, lvl, len, keep;
        bit ok;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(baud_out === 1'b0, "R1 reset out", int'(baud_out), 0);
        chk(ab_busy === 1'b0, "R1 reset busy", int'(ab_busy), 0);
        rst = 1'b0;

        // table of ratio vectors
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk); cfg_en = 1'b0;
            @(negedge clk);
            cfg_src   = 2'(VEC[v][0]);
            cfg_pre16 = 1'(VEC[v][1]);
            cfg_div   = 12'(VEC[v][2]);
            cfg_en    = 1'b1;
            measure(h, l);
            chk(h == VEC[v][3], $sformatf("R%0d vec%0d high", VEC[v][5], v), h, VEC[v][3]);
            chk(l == VEC[v][4], $sformatf("R%0d vec%0d low", VEC[v][5], v), l, VEC[v][4]);
        end

        // R3 ratio 1 on the internal source: steady high
        @(negedge clk); cfg_en = 1'b0;
        @(negedge clk); cfg_src = 2'd0; cfg_pre16 = 1'b0; cfg_div = 12'd0; cfg_en = 1'b1;
        repeat (3) @(negedge clk);
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (baud_out !== 1'b1) ok = 1'b0; end
        chk(ok, "R3 steady high", int'(ok), 1);

        // R7 on-the-fly change taken at terminal count
        @(negedge clk); cfg_en = 1'b0;
        @(negedge clk); cfg_div = 12'd3; cfg_en = 1'b1;
        measure(h, l);                 // ends on the first high sample
        cfg_div = 12'd7;
        lvl = 1; len = 1; nr = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (baud_out === lvl[0]) len++;
            else begin
                if (nr < 3) runs[nr] = len;
                nr++; lvl = int'(baud_out); len = 1;
            end
        end
        chk(nr >= 3 && runs[0] == 2, "R7 old phase completes", runs[0], 2);
        chk(nr >= 3 && runs[1] == 4 && runs[2] == 4, "R7 new ratio", runs[1], 4);

        // R6 source code 3 freezes the output
        cfg_src = 2'd3;
        keep = int'(baud_out);
        ok = 1'b1;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (int'(baud_out) != keep) ok = 1'b0; end
        chk(ok, "R6 frozen", int'(ok), 1);
        cfg_src = 2'd0;
        measure(h, l);
        chk(h == 4 && l == 4, "R6 resumes", h, 4);

        // R1 disable forces low
        while (baud_out !== 1'b1) @(negedge clk);
        cfg_en = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (baud_out !== 1'b0) ok = 1'b0; end
        chk(ok, "R1 disabled low", int'(ok), 1);

        // R9 arm while running
        @(negedge clk); cfg_div = 12'd3; cfg_en = 1'b1;
        repeat (10) @(negedge clk);
        while (baud_out !== 1'b1) @(negedge clk);
        ab_arm = 1'b1;
        @(negedge clk); ab_arm = 1'b0;
        chk(ab_busy === 1'b1, "R9 busy set", int'(ab_busy), 1);
        repeat (2) @(negedge clk);
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin if (baud_out !== 1'b0) ok = 1'b0; @(negedge clk); end
        chk(ok, "R9 held low", int'(ok), 1);

        // R8 start edge timing
        rxd = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(ab_busy === 1'b1, "R8 busy edge2", int'(ab_busy), 1);
        @(negedge clk);
        chk(ab_busy === 1'b0, "R8 busy cleared edge3", int'(ab_busy), 0);
        @(negedge clk);
        chk(baud_out === 1'b0, "R8 low edge4", int'(baud_out), 0);
        @(negedge clk);
        chk(baud_out === 1'b1, "R8 high edge5", int'(baud_out), 1);
        measure(h, l);
        chk(h == 2 && l == 2, "R8 runs after start", h, 2);

        // R1 reset clears a pending request
        rxd = 1'b1;
        ab_arm = 1'b1;
        @(negedge clk); ab_arm = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk(ab_busy === 1'b0 && baud_out === 1'b0, "R1 reset clears busy", int'(ab_busy), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule